// File: doc/BRIEF.md
# Lockable CMOS RAM access guard

This block guards host access to a battery-backed byte RAM built as two banks of 128 bytes, a lower one and an upper one. A 32-bit configuration word sets the access rules. The upper bank has a master enable. Each bank also has a lock that protects one fixed 8-byte window at offsets 38h to 3Fh. Once a lock is set, only a system reset clears it.

The host uses two ports. The configuration port writes the configuration word and reads it back at any time. The byte port carries a request, a write flag, a bank select and a 7-bit offset. It can read or write one byte per cycle. A write to a protected byte is dropped, and a read of a protected byte returns FFh. The RAM array is internal to the block and keeps its contents through reset.

Top module: `cmos_ram_guard`

## Requirements
- R1: While `rst_n` is low at a rising edge, the configuration word becomes 0 and `ram_rdata` becomes 00h. Byte requests in that cycle have no effect.
- R2: Bits 31:5 and 1:0 of the configuration word always read 0, whatever value is written to them.
- R3: Bit 3 (lower lock) is set by writing 1. Later writes of 0 leave it set. Only reset clears it.
- R4: Bit 4 (upper lock) is set by writing 1. Later writes of 0 leave it set. Only reset clears it.
- R5: Bit 2 (upper enable) takes the written value on every configuration write, including after either lock has been set.
- R6: While bit 2 is 0, every write to the upper bank (`ram_bank`=1) is dropped and every read of it returns FFh.
- R7: While bit 3 is 1, writes to lower-bank offsets 38h–3Fh are dropped and reads of them return FFh. Offsets 37h and 40h stay accessible.
- R8: While bits 4 and 2 are both 1, upper-bank offsets 38h–3Fh behave as in R7. The rest of the upper bank stays accessible.
- R9: A permitted read returns the byte last written at that bank and offset. `ram_rdata` changes on the edge that takes the read request and then holds until the next read.
- R10: Reset does not alter the RAM contents.
- R11: A byte request is judged against the configuration word as it stood before any configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rdata | output | 32 | Current configuration word |
| ram_req | input | 1 | Byte access request |
| ram_we | input | 1 | 1 = write, 0 = read |
| ram_bank | input | 1 | 0 = lower bank, 1 = upper bank |
| ram_ofs | input | 7 | Byte offset within the bank |
| ram_wdata | input | 8 | Write byte |
| ram_rdata | output | 8 | Registered read byte |

## Verification
The bench uses the default parameters: 128-byte banks, a window from 38h to 3Fh, a fill value of FFh and a 32-bit configuration word. With these values it can fill every byte of both banks and then probe offsets 37h, 38h, 3Fh and 40h in each bank, which are the edges of the protected window. It covers these cases:
- It tries to clear each lock bit after setting it.
- It turns the upper enable off and on again while a lock is held.
- It resets the block in the middle of the test to show that the RAM contents survive reset.

// File: rtl/cmos_guard_pkg.sv
// Package: shared configuration layout for the CMOS RAM access guard.
// Assumes bit positions are fixed by the host software contract.
package cmos_guard_pkg;

    // Bit positions inside the configuration word.
    localparam int BIT_UPPER_LOCK = 4;
    localparam int BIT_LOWER_LOCK = 3;
    localparam int BIT_UPPER_EN   = 2;

    // Decoded configuration state.
    typedef struct packed {
        logic upper_lock;
        logic lower_lock;
        logic upper_en;
    } guard_cfg_t;

endpackage

// File: rtl/guard_cfg_reg.sv
// Module: configuration register holding two sticky locks and the upper-bank enable.
// Assumes: CFG_W is wider than the highest used bit; reserved bits are not stored.
module guard_cfg_reg
    import cmos_guard_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output guard_cfg_t       cfg,
    output logic [CFG_W-1:0] rdata
);

    guard_cfg_t cfg_q;
    logic       wdata_unused;

    // Reserved write bits are intentionally discarded.
    assign wdata_unused = ^wdata;

    // Register update: locks only set, enable follows each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.upper_lock <= cfg_q.upper_lock | wdata[BIT_UPPER_LOCK];
            cfg_q.lower_lock <= cfg_q.lower_lock | wdata[BIT_LOWER_LOCK];
            cfg_q.upper_en   <= wdata[BIT_UPPER_EN];
        end
    end

    // Read-back word: stored bits in place, reserved bits zero.
    always_comb begin
        rdata                 = '0;
        rdata[BIT_UPPER_LOCK] = cfg_q.upper_lock;
        rdata[BIT_LOWER_LOCK] = cfg_q.lower_lock;
        rdata[BIT_UPPER_EN]   = cfg_q.upper_en;
    end

    assign cfg = cfg_q;

    assert_lower_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lower_lock |=> cfg_q.lower_lock);

    assert_upper_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.upper_lock |=> cfg_q.upper_lock);

endmodule

// File: rtl/guard_access_check.sv
// Module: decides whether a byte access is permitted.
// Assumes: bank 0 is lower, bank 1 is upper; window bounds fit in OFS_W bits.
module guard_access_check
    import cmos_guard_pkg::*;
#(
    parameter int OFS_W  = 7,
    parameter int WIN_LO = 'h38,
    parameter int WIN_HI = 'h3F
) (
    input  guard_cfg_t       cfg,
    input  logic             bank,
    input  logic [OFS_W-1:0] ofs,
    output logic             in_win,
    output logic             allow
);

    localparam logic [OFS_W-1:0] LO = OFS_W'(WIN_LO);
    localparam logic [OFS_W-1:0] HI = OFS_W'(WIN_HI);

    // Window detection on the offset.
    assign in_win = (ofs >= LO) && (ofs <= HI);

    // Permission: upper needs enable and no window lock; lower needs no window lock.
    always_comb begin
        if (bank) begin
            allow = cfg.upper_en && !(cfg.upper_lock && in_win);
        end else begin
            allow = !(cfg.lower_lock && in_win);
        end
    end

endmodule

// File: rtl/guard_ram_bank.sv
// Module: one byte-wide RAM bank with combinational read.
// Assumes: contents are never reset; write happens on the rising edge.
module guard_ram_bank #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    // Asynchronous read port.
    assign rdata = mem[addr];

endmodule

// File: rtl/cmos_ram_guard.sv
// Module: top of the guard; two RAM banks behind a lock/enable permission check.
// Assumes: one byte request per cycle; permission uses the configuration value
// held before any configuration write in the same cycle.
module cmos_ram_guard
    import cmos_guard_pkg::*;
#(
    parameter int              BANK_BYTES = 128,
    parameter int              DATA_W     = 8,
    parameter int              CFG_W      = 32,
    parameter int              WIN_LO     = 'h38,
    parameter int              WIN_HI     = 'h3F,
    parameter logic [7:0]      FILL       = 8'hFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [CFG_W-1:0]              cfg_wdata,
    output logic [CFG_W-1:0]              cfg_rdata,
    input  logic                          ram_req,
    input  logic                          ram_we,
    input  logic                          ram_bank,
    input  logic [$clog2(BANK_BYTES)-1:0] ram_ofs,
    input  logic [DATA_W-1:0]             ram_wdata,
    output logic [DATA_W-1:0]             ram_rdata
);

    localparam int OFS_W     = $clog2(BANK_BYTES);
    localparam int NUM_BANKS = 2;

    guard_cfg_t        cfg;
    logic              in_win;
    logic              allow;
    logic              wr_ok;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    guard_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    guard_access_check #(.OFS_W(OFS_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_check (
        .cfg    (cfg),
        .bank   (ram_bank),
        .ofs    (ram_ofs),
        .in_win (in_win),
        .allow  (allow)
    );

    // Write permission: only outside reset, on a permitted write request.
    assign wr_ok = rst_n && ram_req && ram_we && allow;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        guard_ram_bank #(.DEPTH(BANK_BYTES), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .wr_en (wr_ok && (ram_bank == 1'(b))),
            .addr  (ram_ofs),
            .wdata (ram_wdata),
            .rdata (bank_rd[b])
        );
    end

    // Read data register: captures permitted byte or fill value on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_rdata <= '0;
        end else if (ram_req && !ram_we) begin
            ram_rdata <= allow ? bank_rd[ram_bank] : DATA_W'(FILL);
        end
    end

    assert_upper_disabled_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_we && ram_bank && !cfg.upper_en) |=> ram_rdata == DATA_W'(FILL));

    assert_lower_window_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_we && !ram_bank && cfg.lower_lock && in_win)
        |=> ram_rdata == DATA_W'(FILL));

    assert_upper_window_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_we && ram_bank && cfg.upper_lock && in_win)
        |=> ram_rdata == DATA_W'(FILL));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_req && !ram_we) |=> $stable(ram_rdata));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata[CFG_W-1:5] == '0) && (cfg_rdata[1:0] == 2'b00));

endmodule

// File: tb/cmos_ram_guard_bench.sv
// Bench: behavioural reference model compared with the design on every clock.
module cmos_ram_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ram_req = 1'b0;
    logic        ram_we = 1'b0;
    logic        ram_bank = 1'b0;
    logic [6:0]  ram_ofs = '0;
    logic [7:0]  ram_wdata = '0;
    logic [7:0]  ram_rdata;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // Reference state.
    bit [7:0] m_mem [2][128];
    bit       m_ul, m_ll, m_ue;
    bit [7:0] m_rd;

    always #4 clk = ~clk;

    cmos_ram_guard u_cmos_ram_guard (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ram_req(ram_req), .ram_we(ram_we),
        .ram_bank(ram_bank), .ram_ofs(ram_ofs), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    function automatic bit permitted(bit bank, int ofs);
        bit win = (ofs >= 'h38) && (ofs <= 'h3F);
        if (bank) return m_ue && !(m_ul && win);
        return !(m_ll && win);
    endfunction

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: model the edge, then compare at the falling edge and clear inputs.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_ul = 0; m_ll = 0; m_ue = 0; m_rd = 8'h00;
        end else begin
            if (ram_req) begin
                bit ok = permitted(ram_bank, int'(ram_ofs));
                if (ram_we && ok) m_mem[ram_bank][ram_ofs] = ram_wdata;
                if (!ram_we) m_rd = ok ? m_mem[ram_bank][ram_ofs] : 8'hFF;
            end
            if (cfg_wr) begin
                m_ll = m_ll | cfg_wdata[3];
                m_ul = m_ul | cfg_wdata[4];
                m_ue = cfg_wdata[2];
            end
        end
        @(negedge clk);
        check("cfg_rdata", cfg_rdata, {27'b0, m_ul, m_ll, m_ue, 2'b00});
        check("ram_rdata", {24'b0, ram_rdata}, {24'b0, m_rd});
        cfg_wr = 0; ram_req = 0; ram_we = 0;
    endtask

    task automatic cfg_write(logic [31:0] v);
        cfg_wr = 1; cfg_wdata = v; tick();
    endtask

    task automatic ram_write(bit b, int o, logic [7:0] d);
        ram_req = 1; ram_we = 1; ram_bank = b; ram_ofs = 7'(o); ram_wdata = d; tick();
    endtask

    task automatic ram_read(bit b, int o);
        ram_req = 1; ram_we = 0; ram_bank = b; ram_ofs = 7'(o); tick();
        tick(); // idle cycle: R9 holding of read data
    endtask

    task automatic probe_edges(bit b);
        ram_read(b, 'h37); ram_read(b, 'h38); ram_read(b, 'h3A);
        ram_read(b, 'h3F); ram_read(b, 'h40); ram_read(b, 'h7F); ram_read(b, 0);
    endtask

    initial begin
        // R1: reset state, requests during reset ignored.
        tag = "R1";
        ram_req = 1; ram_we = 1; ram_bank = 0; ram_ofs = 7'h05; ram_wdata = 8'h11;
        tick(); tick(); tick();
        rst_n = 1; tick();

        // R2: reserved bits read 0; also enables upper bank.
        tag = "R2";
        cfg_write(32'hFFFF_FFE7);
        tick();

        // R9: fill both banks, read back including window edges.
        tag = "R9";
        for (int b = 0; b < 2; b++)
            for (int o = 0; o < 128; o++)
                ram_write(b[0], o, 8'((b * 128 + o) ^ 'h5A));
        probe_edges(0); probe_edges(1);

        // R6: upper bank disabled.
        tag = "R6";
        cfg_write(32'h0);
        ram_write(1, 'h10, 8'h99);
        ram_read(1, 'h10); ram_read(1, 'h3A); ram_read(0, 'h10);
        // R5: enable again, dropped write must not show.
        tag = "R5";
        cfg_write(32'h4);
        ram_read(1, 'h10);

        // R11: byte access in the same cycle as a disabling configuration write.
        tag = "R11";
        cfg_wr = 1; cfg_wdata = 32'h0; ram_req = 1; ram_we = 0; ram_bank = 1; ram_ofs = 7'h20;
        tick();
        cfg_write(32'h4);

        // R7 and R3: lower lock.
        tag = "R7";
        cfg_write(32'h0C);
        probe_edges(0);
        ram_write(0, 'h3A, 8'hC3); ram_write(0, 'h37, 8'h3C); ram_write(0, 'h40, 8'h4D);
        probe_edges(0);
        tag = "R3";
        cfg_write(32'h04);
        ram_read(0, 'h3A);
        tag = "R5";
        cfg_write(32'h08);
        ram_read(1, 'h05);
        cfg_write(32'h0C);

        // R8 and R4: upper lock.
        tag = "R8";
        cfg_write(32'h14);
        probe_edges(1);
        ram_write(1, 'h3C, 8'hE1); ram_write(1, 'h37, 8'h71);
        probe_edges(1);
        tag = "R4";
        cfg_write(32'h04);
        ram_read(1, 'h3C);

        // R10: reset keeps RAM; locks cleared.
        tag = "R10";
        rst_n = 0; tick(); tick();
        rst_n = 1; tick();
        cfg_write(32'h4);
        probe_edges(0); probe_edges(1);
        ram_write(0, 'h3A, 8'hA5); ram_read(0, 'h3A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog %s actual timeout expected completion", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule